// File: doc/BRIEF.md
# AHB Peripheral Security Access Gate

This block sits on the path between an AHB-Lite master port and a group of peripheral slots. It decodes the target slot from a field of the address. It then checks the transfer's security attribute (HNONSEC) and its privilege bit (HPROT[1]) against two configuration bits held for that slot: one marks the slot secure, the other marks it privileged. A legal transfer passes through untouched: the slot's select goes high and the downstream response comes back in the data phase.

An illegal transfer never reaches the peripheral. The gate holds every downstream select low and answers the data phase itself. It returns all-zero read data, a zero-wait-state ready and an OKAY response, so a blocked write is simply discarded. The two kinds of violation are treated differently:

- A non-secure access to a secure slot sets a sticky per-slot event flag.
- An unprivileged access to a privileged slot is rejected silently.

When a transfer breaks both rules, it counts as a security violation. Each flag stays set until a one-cycle clear pulse for that slot arrives.

Top module: `ahb_sec_gate`

## Requirements
- R1: A transfer whose attributes are legal for its slot drives that slot's bit of `m_hsel` high in the address phase. In the following data phase, `m_hrdata`, `m_hreadyout` and `m_hresp` appear unchanged on the upstream response ports.
- R2: The slot index is `s_haddr[SLOT_LSB +: SLOT_W]`, and bit `i` of `m_hsel` belongs to slot `i`. At most one bit of `m_hsel` is ever high.
- R3: When `s_hnonsec`=1 and the addressed slot has `cfg_slot_secure`=1, every bit of `m_hsel` stays 0, so reads and writes never reach the slot.
- R4: In the data phase of any blocked transfer, `s_hrdata` is all zero, `s_hreadyout` is 1 and `s_hresp` is 0 (OKAY). This holds whatever the downstream response signals carry.
- R5: An accepted transfer (`s_hsel`=1, `s_htrans[1]`=1, `s_hready_in`=1) with `s_hnonsec`=1 to a secure slot sets `sec_flag` for that slot. The flag is visible from the cycle after the address phase.
- R6: When `s_hprot[1]`=0 and the addressed slot has `cfg_slot_priv`=1, the transfer is blocked with every bit of `m_hsel` at 0. If the security check alone would let it pass, no flag is set.
- R7: A secure transfer (`s_hnonsec`=0) to a non-secure slot is legal, as is a secure transfer to a secure slot when privilege allows it.
- R8: A transfer that violates both attributes sets the security flag of its slot.
- R9: `sec_flag[i]` stays set until `sec_clr[i]` is 1 at a clock edge. A clear affects only its own slot. When a set and a clear hit the same slot at the same edge, the set wins.
- R10: An IDLE transfer (`s_htrans[1]`=0) or an address phase with `s_hready_in`=0 sets no flag and is not answered as blocked.
- R11: After reset all flags are 0 and the upstream response follows the downstream response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| s_hsel | input | 1 | Upstream select for the whole gated region |
| s_haddr | input | ADDR_W | Upstream address |
| s_htrans | input | 2 | Upstream transfer type |
| s_hwrite | input | 1 | Upstream write flag |
| s_hprot | input | 4 | Upstream protection; bit 1 = privileged |
| s_hnonsec | input | 1 | Upstream security: 1 = non-secure |
| s_hready_in | input | 1 | Bus-wide ready, marks an accepted address phase |
| s_hreadyout | output | 1 | Ready returned upstream |
| s_hresp | output | 1 | Response returned upstream, 0 = OKAY |
| s_hrdata | output | DATA_W | Read data returned upstream |
| m_hsel | output | NUM_SLOTS | Per-slot downstream select |
| m_haddr | output | ADDR_W | Downstream address |
| m_htrans | output | 2 | Downstream transfer type |
| m_hwrite | output | 1 | Downstream write flag |
| m_hprot | output | 4 | Downstream protection |
| m_hnonsec | output | 1 | Downstream security attribute |
| m_hrdata | input | DATA_W | Read data from the slot multiplexer |
| m_hreadyout | input | 1 | Ready from the slot multiplexer |
| m_hresp | input | 1 | Response from the slot multiplexer |
| cfg_slot_secure | input | NUM_SLOTS | Per-slot secure attribute |
| cfg_slot_priv | input | NUM_SLOTS | Per-slot privileged attribute |
| sec_clr | input | NUM_SLOTS | Per-slot flag clear pulse |
| sec_flag | output | NUM_SLOTS | Per-slot sticky security-violation flag |

## Verification
The hardest case to create from the ports is a blocked data phase while the downstream side reports something contradictory. The bench forces `m_hreadyout` low and `m_hresp` high during a blocked read and expects the gate to still return a ready, OKAY, zero-data answer. A second hard case is a set and a clear hitting the same flag at one edge. The bench lines up a violating address phase with the clear pulse for that slot in the same cycle. It also clears a neighbouring slot to show that the clears are independent.

// File: rtl/ahb_sec_pkg.sv
package ahb_sec_pkg;

  localparam int HPROT_PRIV_BIT = 1;

  typedef enum logic [1:0] {
    VERDICT_PASS = 2'd0,
    VERDICT_PRIV = 2'd1,
    VERDICT_SEC  = 2'd2
  } verdict_e;

  // Security outranks privilege when both are broken.
  function automatic verdict_e judge(input logic nonsec, input logic privileged,
                                     input logic slot_secure, input logic slot_priv);
    if (nonsec && slot_secure) return VERDICT_SEC;
    if (!privileged && slot_priv) return VERDICT_PRIV;
    return VERDICT_PASS;
  endfunction

endpackage

// File: rtl/ahb_sec_decode.sv
module ahb_sec_decode
  import ahb_sec_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic [SLOT_W-1:0]    slot_idx,
  input  logic                 nonsec,
  input  logic                 privileged,
  input  logic [NUM_SLOTS-1:0] cfg_secure,
  input  logic [NUM_SLOTS-1:0] cfg_priv,
  output logic [NUM_SLOTS-1:0] slot_onehot,
  output verdict_e             verdict
);
  logic slot_secure;
  logic slot_priv;

  always_comb begin
    for (int i = 0; i < NUM_SLOTS; i++) begin
      slot_onehot[i] = (slot_idx == SLOT_W'(i));
    end
  end

  assign slot_secure = |(cfg_secure & slot_onehot);
  assign slot_priv   = |(cfg_priv & slot_onehot);
  assign verdict     = judge(nonsec, privileged, slot_secure, slot_priv);
endmodule

// File: rtl/ahb_sec_resp.sv
module ahb_sec_resp #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hready_in,
  input  logic              blk_addr,
  input  logic [DATA_W-1:0] dn_hrdata,
  input  logic              dn_hreadyout,
  input  logic              dn_hresp,
  output logic              blk_dp,
  output logic [DATA_W-1:0] up_hrdata,
  output logic              up_hreadyout,
  output logic              up_hresp
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         blk_dp <= 1'b0;
    else if (hready_in) blk_dp <= blk_addr;
  end

  assign up_hrdata    = blk_dp ? '0   : dn_hrdata;
  assign up_hreadyout = blk_dp ? 1'b1 : dn_hreadyout;
  assign up_hresp     = blk_dp ? 1'b0 : dn_hresp;
endmodule

// File: rtl/ahb_sec_flags.sv
module ahb_sec_flags #(
  parameter int NUM_SLOTS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sec_hit,
  input  logic [NUM_SLOTS-1:0] slot_onehot,
  input  logic [NUM_SLOTS-1:0] clr,
  output logic [NUM_SLOTS-1:0] flag
);
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic set_g;
    assign set_g = sec_hit & slot_onehot[g];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag[g] <= 1'b0;
      else        flag[g] <= set_g | (flag[g] & ~clr[g]);
    end
  end
endmodule

// File: rtl/ahb_sec_gate.sv
module ahb_sec_gate
  import ahb_sec_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int NUM_SLOTS = 4,
  parameter int SLOT_LSB  = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 s_hsel,
  input  logic [ADDR_W-1:0]    s_haddr,
  input  logic [1:0]           s_htrans,
  input  logic                 s_hwrite,
  input  logic [3:0]           s_hprot,
  input  logic                 s_hnonsec,
  input  logic                 s_hready_in,
  output logic                 s_hreadyout,
  output logic                 s_hresp,
  output logic [DATA_W-1:0]    s_hrdata,
  output logic [NUM_SLOTS-1:0] m_hsel,
  output logic [ADDR_W-1:0]    m_haddr,
  output logic [1:0]           m_htrans,
  output logic                 m_hwrite,
  output logic [3:0]           m_hprot,
  output logic                 m_hnonsec,
  input  logic [DATA_W-1:0]    m_hrdata,
  input  logic                 m_hreadyout,
  input  logic                 m_hresp,
  input  logic [NUM_SLOTS-1:0] cfg_slot_secure,
  input  logic [NUM_SLOTS-1:0] cfg_slot_priv,
  input  logic [NUM_SLOTS-1:0] sec_clr,
  output logic [NUM_SLOTS-1:0] sec_flag
);
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

  logic [SLOT_W-1:0]    slot_idx;
  logic [NUM_SLOTS-1:0] slot_onehot;
  verdict_e             verdict;
  logic                 xfer_accept;
  logic                 blk_addr;
  logic                 sec_hit;
  logic                 blk_dp;

  assign slot_idx    = s_haddr[SLOT_LSB +: SLOT_W];
  assign xfer_accept = s_hsel & s_htrans[1] & s_hready_in;

  ahb_sec_decode #(.NUM_SLOTS(NUM_SLOTS)) u_decode (
    .slot_idx    (slot_idx),
    .nonsec      (s_hnonsec),
    .privileged  (s_hprot[HPROT_PRIV_BIT]),
    .cfg_secure  (cfg_slot_secure),
    .cfg_priv    (cfg_slot_priv),
    .slot_onehot (slot_onehot),
    .verdict     (verdict)
  );

  assign blk_addr = xfer_accept & (verdict != VERDICT_PASS);
  assign sec_hit  = xfer_accept & (verdict == VERDICT_SEC);

  assign m_hsel    = (s_hsel && verdict == VERDICT_PASS) ? slot_onehot : '0;
  assign m_haddr   = s_haddr;
  assign m_htrans  = s_htrans;
  assign m_hwrite  = s_hwrite;
  assign m_hprot   = s_hprot;
  assign m_hnonsec = s_hnonsec;

  ahb_sec_resp #(.DATA_W(DATA_W)) u_resp (
    .clk          (clk),
    .rst_n        (rst_n),
    .hready_in    (s_hready_in),
    .blk_addr     (blk_addr),
    .dn_hrdata    (m_hrdata),
    .dn_hreadyout (m_hreadyout),
    .dn_hresp     (m_hresp),
    .blk_dp       (blk_dp),
    .up_hrdata    (s_hrdata),
    .up_hreadyout (s_hreadyout),
    .up_hresp     (s_hresp)
  );

  ahb_sec_flags #(.NUM_SLOTS(NUM_SLOTS)) u_flags (
    .clk         (clk),
    .rst_n       (rst_n),
    .sec_hit     (sec_hit),
    .slot_onehot (slot_onehot),
    .clr         (sec_clr),
    .flag        (sec_flag)
  );
endmodule

// File: rtl/ahb_sec_gate_chk.sv
module ahb_sec_gate_chk #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int NUM_SLOTS = 4,
  parameter int SLOT_LSB  = 12
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 s_hsel,
  input logic [ADDR_W-1:0]    s_haddr,
  input logic [1:0]           s_htrans,
  input logic                 s_hprot_priv,
  input logic                 s_hnonsec,
  input logic                 s_hready_in,
  input logic                 s_hreadyout,
  input logic                 s_hresp,
  input logic [DATA_W-1:0]    s_hrdata,
  input logic [NUM_SLOTS-1:0] m_hsel,
  input logic [NUM_SLOTS-1:0] cfg_slot_secure,
  input logic [NUM_SLOTS-1:0] cfg_slot_priv,
  input logic [NUM_SLOTS-1:0] sec_clr,
  input logic [NUM_SLOTS-1:0] sec_flag,
  input logic                 blk_dp
);
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

  logic [NUM_SLOTS-1:0] hit;
  logic acc, sec_v, priv_v;

  always_comb begin
    for (int i = 0; i < NUM_SLOTS; i++)
      hit[i] = (s_haddr[SLOT_LSB +: SLOT_W] == SLOT_W'(i));
  end
  assign acc    = s_hsel & s_htrans[1] & s_hready_in;
  assign sec_v  = s_hnonsec & |(cfg_slot_secure & hit);
  assign priv_v = ~s_hprot_priv & |(cfg_slot_priv & hit);

  p_sel_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(m_hsel));

  p_pass_sel_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (s_hsel && !sec_v && !priv_v) |-> (m_hsel == hit));

  p_sec_nosel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (s_hsel && sec_v) |-> (m_hsel == '0));

  p_priv_nosel_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (s_hsel && priv_v) |-> (m_hsel == '0));

  p_okay_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (sec_v || priv_v)) |=> (s_hreadyout && !s_hresp && s_hrdata == '0));

  p_blk_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    blk_dp |-> (s_hreadyout && !s_hresp));

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    p_flag_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && sec_v && hit[g]) |=> sec_flag[g]);

    p_flag_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_flag[g] && !sec_clr[g]) |=> sec_flag[g]);

    p_flag_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sec_flag[g]) |-> $past(acc && sec_v && hit[g]));
  end
endmodule

bind ahb_sec_gate ahb_sec_gate_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SLOTS(NUM_SLOTS), .SLOT_LSB(SLOT_LSB)
) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .s_hsel          (s_hsel),
  .s_haddr         (s_haddr),
  .s_htrans        (s_htrans),
  .s_hprot_priv    (s_hprot[1]),
  .s_hnonsec       (s_hnonsec),
  .s_hready_in     (s_hready_in),
  .s_hreadyout     (s_hreadyout),
  .s_hresp         (s_hresp),
  .s_hrdata        (s_hrdata),
  .m_hsel          (m_hsel),
  .cfg_slot_secure (cfg_slot_secure),
  .cfg_slot_priv   (cfg_slot_priv),
  .sec_clr         (sec_clr),
  .sec_flag        (sec_flag),
  .blk_dp          (blk_dp)
);

// File: tb/test_ahb_sec_gate.sv
module test_ahb_sec_gate;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int NS     = 4;
  localparam int LSB    = 12;

  // {slot[1:0], nonsec, prot1, cfg_sec, cfg_priv, exp_blocked, exp_flag, write}
  localparam logic [8:0] VEC [16] = '{
    9'b00_0000_00_0, 9'b11_0001_10_1, 9'b10_0010_00_0, 9'b01_0011_10_1,
    9'b00_0100_00_0, 9'b11_0101_00_1, 9'b10_0110_00_0, 9'b01_0111_00_1,
    9'b00_1000_00_1, 9'b11_1001_10_0, 9'b10_1010_11_1, 9'b01_1011_11_0,
    9'b00_1100_00_1, 9'b11_1101_00_0, 9'b10_1110_11_1, 9'b01_1111_11_0
  };

  logic clk = 0, rst_n = 0;
  logic s_hsel = 0, s_hwrite = 0, s_hnonsec = 0, s_hready_in = 1;
  logic [ADDR_W-1:0] s_haddr = '0;
  logic [1:0] s_htrans = 2'b00;
  logic [3:0] s_hprot = 4'b0011;
  logic s_hreadyout, s_hresp;
  logic [DATA_W-1:0] s_hrdata;
  logic [NS-1:0] m_hsel;
  logic [ADDR_W-1:0] m_haddr;
  logic [1:0] m_htrans;
  logic m_hwrite, m_hnonsec;
  logic [3:0] m_hprot;
  logic [DATA_W-1:0] m_hrdata = 32'hA5A5_0000;
  logic m_hreadyout = 1, m_hresp = 0;
  logic [NS-1:0] cfg_sec = '0, cfg_priv = '0, clr = '0, flag;

  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  ahb_sec_gate #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SLOTS(NS), .SLOT_LSB(LSB)) i_ahb_sec_gate (
    .clk(clk), .rst_n(rst_n), .s_hsel(s_hsel), .s_haddr(s_haddr), .s_htrans(s_htrans),
    .s_hwrite(s_hwrite), .s_hprot(s_hprot), .s_hnonsec(s_hnonsec), .s_hready_in(s_hready_in),
    .s_hreadyout(s_hreadyout), .s_hresp(s_hresp), .s_hrdata(s_hrdata), .m_hsel(m_hsel),
    .m_haddr(m_haddr), .m_htrans(m_htrans), .m_hwrite(m_hwrite), .m_hprot(m_hprot),
    .m_hnonsec(m_hnonsec), .m_hrdata(m_hrdata), .m_hreadyout(m_hreadyout), .m_hresp(m_hresp),
    .cfg_slot_secure(cfg_sec), .cfg_slot_priv(cfg_priv), .sec_clr(clr), .sec_flag(flag)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive an address phase at the falling edge; the edge after it accepts it.
  task automatic addr_phase(input int slot, input logic ns, input logic p1, input logic wr,
                            input logic [1:0] tr);
    s_hsel    = 1;
    s_haddr   = 32'h4000_00A4 | (32'(slot) << LSB) | 32'h0010_0000;
    s_htrans  = tr;
    s_hwrite  = wr;
    s_hnonsec = ns;
    s_hprot   = {2'b00, p1, 1'b1};
  endtask

  task automatic go_idle();
    s_hsel = 0; s_htrans = 2'b00; s_hnonsec = 0; s_hprot = 4'b0011;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R11 flags after reset", 64'(flag), 64'h0);
    check("R11 readyout after reset", 64'(s_hreadyout), 64'h1);
    check("R11 rdata passes after reset", 64'(s_hrdata), 64'hA5A5_0000);
    @(negedge clk);
    rst_n = 1;

    // Table walk: R1 R2 R3 R4 R5 R6 R7 R8
    for (int i = 0; i < 16; i++) begin
      logic [8:0] v;
      int sl;
      v  = VEC[i];
      sl = int'(v[8:7]);
      @(negedge clk);
      clr = '1; go_idle();
      @(negedge clk);
      clr = '0;
      cfg_sec = '0; cfg_priv = '0;
      cfg_sec[sl] = v[4]; cfg_priv[sl] = v[3];
      m_hrdata = 32'hA5A5_0000 | 32'(sl);
      addr_phase(sl, v[6], v[5], v[0], 2'b10);
      #1;
      check($sformatf("R1/R2/R3/R6 hsel vec %0d", i), 64'(m_hsel),
            v[2] ? 64'h0 : (64'h1 << sl));
      @(negedge clk);
      go_idle();
      #1;
      check($sformatf("R4/R1 rdata vec %0d", i), 64'(s_hrdata),
            v[2] ? 64'h0 : 64'(32'hA5A5_0000 | 32'(sl)));
      check($sformatf("R4 ready/okay vec %0d", i), 64'({s_hreadyout, s_hresp}), 64'b10);
      check($sformatf("R5/R6/R7/R8 flag vec %0d", i), 64'(flag),
            v[1] ? (64'h1 << sl) : 64'h0);
    end

    // R4: blocked read while the downstream side claims wait and error
    @(negedge clk);
    clr = '1;
    @(negedge clk);
    clr = '0; cfg_sec = 4'b0100; cfg_priv = '0;
    addr_phase(2, 1'b1, 1'b1, 1'b0, 2'b10);
    @(negedge clk);
    go_idle(); m_hreadyout = 0; m_hresp = 1; m_hrdata = 32'hDEAD_BEEF;
    #1;
    check("R4 blocked answer ignores downstream", 64'({s_hreadyout, s_hresp, s_hrdata}),
          {31'h0, 1'b1, 1'b0, 32'h0});
    @(negedge clk);
    #1;
    check("R1 pass-through of downstream wait", 64'({s_hreadyout, s_hresp}), 64'b01);
    m_hreadyout = 1; m_hresp = 0;

    // R9: sticky, neighbour clear, own clear
    repeat (3) @(negedge clk);
    #1;
    check("R9 flag sticky", 64'(flag), 64'h4);
    clr = 4'b0010;
    @(negedge clk);
    clr = '0;
    #1;
    check("R9 other-slot clear", 64'(flag), 64'h4);
    clr = 4'b0100;
    @(negedge clk);
    clr = '0;
    #1;
    check("R9 own clear", 64'(flag), 64'h0);

    // R9: set and clear at the same edge, set wins
    addr_phase(2, 1'b1, 1'b1, 1'b1, 2'b11);
    clr = 4'b0100;
    @(negedge clk);
    clr = '0; go_idle();
    #1;
    check("R9 set beats clear", 64'(flag), 64'h4);
    clr = '1;
    @(negedge clk);
    clr = '0;

    // R10: IDLE and stalled address phases change nothing
    addr_phase(2, 1'b1, 1'b1, 1'b0, 2'b00);
    @(negedge clk);
    go_idle();
    #1;
    check("R10 idle sets no flag", 64'(flag), 64'h0);
    check("R10 idle not blocked", 64'(s_hrdata), 64'hDEAD_BEEF);
    addr_phase(2, 1'b1, 1'b1, 1'b0, 2'b10);
    s_hready_in = 0;
    @(negedge clk);
    go_idle(); s_hready_in = 1;
    #1;
    check("R10 stalled phase sets no flag", 64'(flag), 64'h0);

    // R7: secure master into a non-secure privileged slot with privilege
    cfg_sec = 4'b0000; cfg_priv = 4'b1000;
    addr_phase(3, 1'b0, 1'b1, 1'b1, 2'b10);
    #1;
    check("R7 secure to non-secure passes", 64'(m_hsel), 64'h8);
    @(negedge clk);
    go_idle();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule